// File: doc/BRIEF.md
# Block Floating Point Output Normaliser

A transform engine that keeps its dynamic range with block floating point hands out results whose binary points sit in different places. This block turns that stream into words that all share one binary-point position, so they can be shown, stored or sent on without further care. Every result word comes with a 2-bit weighting code. Once per transform, a 5-bit group exponent is loaded. The group exponent plus the weighting code, as an unsigned sum, is the word's complete exponent: the number of places its binary point has moved right. The block subtracts that exponent from a universal exponent and moves the 16-bit two's-complement word by the difference.

The universal exponent is held in a register. Reset sets it to the parameter `UEXP_LOG2N`, meant to be log2(N) for an N-point transform, because a result can grow by at most a factor of N. A write port can replace it at run time, so an application can try other values. A positive difference shifts right arithmetically. A negative difference shifts left, saturating when the value no longer fits. Words stream in with a valid strobe and come out one registered stage later. There is no back-pressure.

The control has two named states. `ST_EMPTY` is entered at reset: no group exponent is held yet, and words that arrive are discarded. `ST_ARMED` means a group exponent is held and words are normalised. Transition T_ARM goes from `ST_EMPTY` to `ST_ARMED` on a group load. Transition T_RELOAD goes from `ST_ARMED` back to `ST_ARMED` on a group load, for the next transform. No transition leaves `ST_ARMED` except reset.

Top module: `bfp_normaliser`

## Requirements
- R1: After reset, `out_valid` and `out_ovf` are low, the block is in `ST_EMPTY`, and the universal exponent equals `UEXP_LOG2N` (default 10).
- R2: While in `ST_EMPTY`, a word presented without a group load in the same cycle produces no output. Once `ST_ARMED` is reached, the block stays there until reset.
- R3: The complete exponent is the unsigned sum of the 5-bit group exponent and the 2-bit weighting code (0 to 3). The shift is the universal exponent minus the complete exponent.
- R4: For a shift of zero or more, the output is the input shifted right arithmetically by that amount, keeping the sign. A shift of 15 or more gives all bits equal to the sign bit. `out_ovf` stays low.
- R5: For a negative shift whose left-shifted result fits in 16 signed bits, the output is the exact left-shifted value and `out_ovf` is low. This includes a result of exactly 0x8000, and a zero input with any left shift.
- R6: When a left-shifted result does not fit, the output is 0x7FFF for a non-negative input and 0x8000 for a negative input, and `out_ovf` is high.
- R7: `out_valid` rises in the cycle after an accepted input word and lasts one cycle per word. Back-to-back words come out back-to-back.
- R8: A universal exponent write applies to a word presented in the same cycle and to all later words.
- R9: A group load applies to a word presented in the same cycle. That word is accepted even when the block is in `ST_EMPTY`.
- R10: `out_ovf` is high only together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| grp_load | input | 1 | Load a new group exponent |
| grp_exp | input | 5 | Group exponent for the current transform |
| uexp_wr | input | 1 | Write the universal exponent |
| uexp_val | input | 6 | New universal exponent |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 16 | Input word, two's complement |
| in_wt | input | 2 | Per-word weighting code |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 16 | Normalised word |
| out_ovf | output | 1 | Output was saturated |

## Verification
Two functions can fall in one cycle with a word: loading a group exponent (or writing the universal exponent), and normalising that word. The bench drives a group load and a universal exponent write in the same cycle as a word, including the very first word after reset while still in `ST_EMPTY`. It expects the word to be accepted and shifted by the new values. A second pair is a left shift and saturation in one word. The bench places the input exactly at the boundary (0x8000 fits, one step further saturates) and compares both data and flag.

// File: rtl/bfpn_pkg.sv
package bfpn_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_ARMED = 1'b1
    } bfpn_state_e;

endpackage

// File: rtl/bfpn_exp_calc.sv
module bfpn_exp_calc #(
    parameter int GW  = 5,
    parameter int WW  = 2,
    parameter int UEW = 6,
    parameter int CEW = GW + 1,
    parameter int SW  = ((UEW > CEW) ? UEW : CEW) + 2
) (
    input  logic [GW-1:0]  grp,
    input  logic [WW-1:0]  wt,
    input  logic [UEW-1:0] uexp,
    output logic [SW-1:0]  shamt
);

    logic [CEW-1:0] cexp;

    always_comb begin
        cexp  = CEW'(grp) + CEW'(wt);
        shamt = SW'(uexp) - SW'(cexp);
    end

endmodule

// File: rtl/bfpn_shifter.sv
module bfpn_shifter #(
    parameter int DW = 16,
    parameter int SW = 8
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] shamt,
    output logic [DW-1:0] dout,
    output logic          ovf
);

    localparam int RW = $clog2(DW);
    localparam int LW = $clog2(DW) + 1;

    logic                 neg;
    logic [SW-1:0]        mag;
    logic [RW-1:0]        ramt;
    logic [LW-1:0]        lamt;
    logic signed [2*DW-1:0] ext;
    logic signed [2*DW-1:0] wide;
    logic [DW:0]          hi;
    logic                 fits;
    logic signed [DW-1:0] stg [RW+1];

    always_comb begin
        neg  = shamt[SW-1];
        mag  = neg ? (SW'(0) - shamt) : shamt;
        ramt = (mag > SW'(DW - 1)) ? RW'(DW - 1) : mag[RW-1:0];
        lamt = (mag > SW'(DW)) ? LW'(DW) : mag[LW-1:0];
    end

    assign stg[0] = din;

    for (genvar i = 0; i < RW; i++) begin : g_rstage
        assign stg[i+1] = ramt[i] ? (stg[i] >>> (1 << i)) : stg[i];
    end

    always_comb begin
        ext  = {{DW{din[DW-1]}}, din};
        wide = ext <<< lamt;
        hi   = wide[2*DW-1:DW-1];
        fits = (&hi) | ~(|hi);
        if (!neg) begin
            dout = stg[RW];
            ovf  = 1'b0;
        end else if (fits) begin
            dout = wide[DW-1:0];
            ovf  = 1'b0;
        end else begin
            dout = din[DW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
            ovf  = 1'b1;
        end
    end

endmodule

// File: rtl/bfp_normaliser.sv
module bfp_normaliser
    import bfpn_pkg::*;
#(
    parameter int DW         = 16,
    parameter int GW         = 5,
    parameter int WW         = 2,
    parameter int UEW        = 6,
    parameter int UEXP_LOG2N = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           grp_load,
    input  logic [GW-1:0]  grp_exp,
    input  logic           uexp_wr,
    input  logic [UEW-1:0] uexp_val,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    input  logic [WW-1:0]  in_wt,
    output logic           out_valid,
    output logic [DW-1:0]  out_data,
    output logic           out_ovf
);

    localparam int CEW = GW + 1;
    localparam int SW  = ((UEW > CEW) ? UEW : CEW) + 2;
    localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINN = {1'b1, {(DW-1){1'b0}}};

    bfpn_state_e    state, state_nx;
    logic [GW-1:0]  grp_q;
    logic [UEW-1:0] uexp_q;
    logic [GW-1:0]  grp_eff;
    logic [UEW-1:0] uexp_eff;
    logic           accept;
    logic [SW-1:0]  shamt;
    logic [DW-1:0]  sh_data;
    logic           sh_ovf;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // transitions T_ARM and T_RELOAD
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (grp_load) state_nx = ST_ARMED;
            ST_ARMED: state_nx = ST_ARMED;
        endcase
    end

    always_comb begin
        grp_eff  = grp_load ? grp_exp : grp_q;
        uexp_eff = uexp_wr ? uexp_val : uexp_q;
        accept   = in_valid && (grp_load || (state == ST_ARMED));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            uexp_q <= UEW'(UEXP_LOG2N);
        end else begin
            grp_q  <= grp_eff;
            uexp_q <= uexp_eff;
        end
    end

    bfpn_exp_calc #(.GW(GW), .WW(WW), .UEW(UEW), .CEW(CEW), .SW(SW)) u_exp (
        .grp   (grp_eff),
        .wt    (in_wt),
        .uexp  (uexp_eff),
        .shamt (shamt)
    );

    bfpn_shifter #(.DW(DW), .SW(SW)) u_shift (
        .din   (in_data),
        .shamt (shamt),
        .dout  (sh_data),
        .ovf   (sh_ovf)
    );

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= accept;
            out_ovf   <= accept & sh_ovf;
            if (accept) out_data <= sh_data;
        end
    end

    AST_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid)); // R7
    AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_EMPTY && !grp_load && in_valid) |=> !out_valid); // R2
    AST_STAY_ARMED: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_ARMED) |=> (state == ST_ARMED)); // R2
    AST_OVF_VALID:  assert property (@(posedge clk) disable iff (!rst_n) out_ovf |-> out_valid); // R10
    AST_SAT_VALUE:  assert property (@(posedge clk) disable iff (!rst_n) out_ovf |-> (out_data == MAXP || out_data == MINN)); // R6

endmodule

// File: tb/bfp_normaliser_test.sv
`timescale 1ns/1ps
module bfp_normaliser_test;

    typedef struct {
        logic [15:0] d;
        bit          o;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_load = 1'b0;
    logic [4:0]  grp_exp = '0;
    logic        uexp_wr = 1'b0;
    logic [5:0]  uexp_val = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_wt = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ovf;

    int checks = 0;
    int errors = 0;
    int m_grp = 0;
    int m_uexp = 10;
    bit m_armed = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bfp_normaliser uut (
        .clk(clk), .rst_n(rst_n), .grp_load(grp_load), .grp_exp(grp_exp),
        .uexp_wr(uexp_wr), .uexp_val(uexp_val), .in_valid(in_valid),
        .in_data(in_data), .in_wt(in_wt), .out_valid(out_valid),
        .out_data(out_data), .out_ovf(out_ovf)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic push_expect(logic [15:0] d, logic [1:0] w, string tag);
        int ce;
        int sh;
        longint v;
        exp_t e;
        ce = m_grp + int'(w);
        sh = m_uexp - ce;
        e.o = 0;
        e.tag = tag;
        if (sh >= 0) begin
            if (sh > 15) sh = 15;
            e.d = 16'($signed(d) >>> sh);
        end else begin
            v = longint'($signed(d)) * (longint'(1) << (-sh));
            if (v > 32767) begin
                e.d = 16'h7FFF; e.o = 1;
            end else if (v < -32768) begin
                e.d = 16'h8000; e.o = 1;
            end else begin
                e.d = v[15:0];
            end
        end
        sb.push_back(e);
    endtask

    task automatic drive(bit gl, int g, bit uw, int u, bit v, logic [15:0] d,
                         logic [1:0] w, string tag);
        @(posedge clk);
        #1;
        grp_load = gl; grp_exp = 5'(g);
        uexp_wr = uw;  uexp_val = 6'(u);
        in_valid = v;  in_data = d; in_wt = w;
        if (gl) begin m_grp = g; m_armed = 1; end
        if (uw) m_uexp = u;
        if (v && m_armed) push_expect(d, w, tag);
    endtask

    task automatic word(logic [15:0] d, logic [1:0] w, string tag);
        drive(0, 0, 0, 0, 1, d, w, tag);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, '0, '0, "");
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(0, "R2 unexpected output", {16'h0, out_data}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.d && out_ovf == e.o, e.tag,
                      {15'h0, out_ovf, out_data}, {15'h0, e.o, e.d});
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_ovf == 0, "R1 reset outputs", {30'h0, out_valid, out_ovf}, 32'h0);

        // R2: words before any group load are dropped
        word(16'h1234, 2'd0, "R2");
        word(16'h8000, 2'd1, "R2");
        idle();
        @(negedge clk);
        check(out_valid == 0, "R2 dropped in empty", {31'h0, out_valid}, 32'h0);

        // R9: first group load together with a word; R1 default universal exponent 10
        drive(1, 3, 0, 0, 1, 16'h4000, 2'd0, "R9 R1 load with word");
        word(16'h4000, 2'd3, "R3 wt3");
        word(16'hEDCB, 2'd1, "R4 negative right shift");
        word(16'h7FFF, 2'd2, "R4 positive right shift");
        idle();

        // R7: single word latency
        word(16'h0100, 2'd0, "R7 word");
        idle();
        @(negedge clk);
        check(out_valid == 1, "R7 one cycle later", {31'h0, out_valid}, 32'h1);
        @(negedge clk);
        check(out_valid == 0, "R7 single pulse", {31'h0, out_valid}, 32'h0);

        // T_RELOAD with left shifts: grp 9, uexp 10
        drive(1, 9, 0, 0, 0, '0, '0, "");
        word(16'h1234, 2'd1, "R3 zero shift");
        word(16'h0123, 2'd3, "R5 left fits");
        word(16'hE000, 2'd3, "R5 exact 0x8000");
        word(16'h2000, 2'd3, "R6 positive saturate");
        word(16'hD000, 2'd3, "R6 negative saturate");
        word(16'h0000, 2'd3, "R5 zero left");
        idle();

        // R8: universal exponent write in same cycle as word
        drive(0, 0, 1, 31, 1, 16'h8001, 2'd0, "R8 uexp bypass");
        word(16'h7FFF, 2'd0, "R4 full right shift");
        word(16'hFFFF, 2'd1, "R4 minus one");
        idle();

        // large left shift: grp 31 wt3, uexp 0
        drive(1, 31, 1, 0, 1, 16'h0000, 2'd3, "R9 R8 both with word");
        word(16'h0001, 2'd3, "R6 huge shift");
        word(16'hFFFF, 2'd0, "R6 huge shift negative");
        idle();

        // group load and uexp write same cycle, modest values
        drive(1, 2, 1, 5, 1, 16'h0C00, 2'd1, "R9 R8 combined");
        word(16'h0C00, 2'd3, "R3 zero diff");
        repeat (4) idle();
        @(negedge clk);
        check(sb.size() == 0, "R7 all words delivered", sb.size(), 32'h0);
        check(out_ovf == 0, "R10 ovf idle", {31'h0, out_ovf}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule